// File: doc/BRIEF.md
# Reset Cause Capture Register

This block keeps a byte-wide record of why the chip last came out of reset. Three internal reset requesters feed it: a watchdog, a clock-failure monitor and a supply-voltage monitor. Each delivers a one-cycle pulse when it fires. The register sits in an always-on domain that only the external reset pin clears. Firmware reads the byte after reset release to learn the cause, and then clears the flags it has dealt with.

When the reset pin is asserted, every flag is wiped. When an internal requester pulses, its own flag is set and the other flags keep their values. Software can clear a flag by writing a zero in its position, but it can never set one. If software clears a flag in the same cycle that its requester pulses, the flag ends up set. Reads are plain combinational views of the flags and change nothing.

Top module: `reset_cause_reg`

## Requirements
- R1: While `pin_rst` is high at a rising edge, every flag becomes 0, so `rd_data` reads 0x00 after that edge. This holds even if requester pulses or a write arrive in the same cycle.
- R2: A `wdog_pulse` at an edge without `pin_rst` sets bit 4 of `rd_data` after that edge.
- R3: A `clkmon_pulse` at an edge without `pin_rst` sets bit 1 of `rd_data` after that edge.
- R4: A `lowv_pulse` at an edge without `pin_rst` sets bit 0 of `rd_data` after that edge.
- R5: A pulse from one requester leaves the flags of the other requesters unchanged.
- R6: Pulses from several requesters in the same cycle set all of their flags.
- R7: A write (`wr_en` high) with 0 in bit 4, bit 1 or bit 0 of `wr_data` clears that flag at the edge, unless its requester pulses in the same cycle.
- R8: A write with 1 in a flag position leaves that flag unchanged, so software can never set a cleared flag.
- R9: When a write clears a flag and that flag's requester pulses in the same cycle, the flag reads 1 afterwards.
- R10: Bits 7, 6, 5, 3 and 2 of `rd_data` always read 0, whatever is written to them.
- R11: With no pin reset, no pulse and no write, all flags hold their values. Reading has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on domain clock |
| pin_rst | input | 1 | External reset pin, synchronous, active high; clears all flags |
| wdog_pulse | input | 1 | One-cycle reset request from the watchdog |
| clkmon_pulse | input | 1 | One-cycle reset request from the clock monitor |
| lowv_pulse | input | 1 | One-cycle reset request from the voltage monitor |
| wr_en | input | 1 | Software byte write strobe |
| wr_data | input | 8 | Write byte; 0 in a flag position clears that flag |
| rd_data | output | 8 | Current flag byte (bit 4 watchdog, bit 1 clock monitor, bit 0 voltage monitor) |

## Verification
The bench sweeps every start state of the three flags, every combination of requester pulses and every write pattern, including no write. After each case it compares the byte with an arithmetic model, so several kinds of error show up.
- A design that lets a software clear win over a set would lose a watchdog cause that fires during the clearing write.
- A design that treats an internal reset like the pin would wipe earlier causes.
- A design that ORs in written ones would let firmware fake a reset cause.
- Writes of all ones to the reserved bits catch a register that stores them.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

    localparam int REG_W = 8;
    localparam int NSRC  = 3;

    // Requester index; order is the vector order inside the block.
    typedef enum logic [1:0] {
        SRC_LOWV   = 2'd0,
        SRC_CLKMON = 2'd1,
        SRC_WDOG   = 2'd2
    } src_e;

    typedef struct packed {
        logic wdog;
        logic clkmon;
        logic lowv;
    } src_vec_t;

    // Bit position of each requester's flag in the software byte.
    function automatic int flag_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            default: return 4;
        endcase
    endfunction

    // Index of the flag at a byte position, or -1 for a reserved bit.
    function automatic int pos_to_idx(input int pos);
        for (int i = 0; i < NSRC; i++) begin
            if (flag_pos(i) == pos) return i;
        end
        return -1;
    endfunction

    function automatic logic [NSRC-1:0] pack_src(input src_vec_t s);
        return {s.wdog, s.clkmon, s.lowv};
    endfunction

endpackage

// File: rtl/rcf_write_decode.sv
module rcf_write_decode
    import rcf_pkg::*;
#(
    parameter int W = REG_W,
    parameter int N = NSRC
) (
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    output logic [N-1:0]  clr_req
);
    logic unused_bits;
    assign unused_bits = ^wr_data;

    for (genvar i = 0; i < N; i++) begin : g_clr
        localparam int POS = flag_pos(i);
        assign clr_req[i] = wr_en && !wr_data[POS];
    end
endmodule

// File: rtl/rcf_flag_cell.sv
module rcf_flag_cell (
    input  logic clk,
    input  logic pin_rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (pin_rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/rcf_read_map.sv
module rcf_read_map
    import rcf_pkg::*;
#(
    parameter int W = REG_W,
    parameter int N = NSRC
) (
    input  logic [N-1:0] flags,
    output logic [W-1:0] byte_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        localparam int IDX = pos_to_idx(b);
        if (IDX >= 0) begin : g_flag
            assign byte_o[b] = flags[IDX];
        end else begin : g_rsvd
            assign byte_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
    import rcf_pkg::*;
(
    input  logic             clk,
    input  logic             pin_rst,
    input  logic             wdog_pulse,
    input  logic             clkmon_pulse,
    input  logic             lowv_pulse,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);
    src_vec_t        req;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] flags;

    always_comb begin
        req.wdog   = wdog_pulse;
        req.clkmon = clkmon_pulse;
        req.lowv   = lowv_pulse;
        set_vec    = pack_src(req);
    end

    rcf_write_decode #(.W(REG_W), .N(NSRC)) u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .clr_req (clr_vec)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        rcf_flag_cell u_cell (
            .clk     (clk),
            .pin_rst (pin_rst),
            .set_i   (set_vec[i]),
            .clr_i   (clr_vec[i]),
            .flag_o  (flags[i])
        );
    end

    rcf_read_map #(.W(REG_W), .N(NSRC)) u_map (
        .flags  (flags),
        .byte_o (rd_data)
    );
endmodule

// File: rtl/rcf_checker.sv
module rcf_checker (
    input logic       clk,
    input logic       pin_rst,
    input logic       wdog_pulse,
    input logic       clkmon_pulse,
    input logic       lowv_pulse,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data
);
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (pin_rst) armed <= 1'b1;
    end

    AST_PIN_CLEAR: assert property (@(posedge clk) disable iff (!armed)
        pin_rst |=> (rd_data == 8'h00)); // R1
    AST_WDOG_SET: assert property (@(posedge clk) disable iff (!armed)
        (!pin_rst && wdog_pulse) |=> rd_data[4]); // R2
    AST_CLKMON_SET: assert property (@(posedge clk) disable iff (!armed)
        (!pin_rst && clkmon_pulse) |=> rd_data[1]); // R3
    AST_LOWV_SET: assert property (@(posedge clk) disable iff (!armed)
        (!pin_rst && lowv_pulse) |=> rd_data[0]); // R4
    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!armed || pin_rst)
        (!wdog_pulse && !rd_data[4]) |=> !rd_data[4]); // R8
    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!armed || pin_rst)
        (wr_en && !wr_data[1] && !clkmon_pulse) |=> !rd_data[1]); // R7
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!armed || pin_rst)
        (wr_en && !wr_data[0] && lowv_pulse) |=> rd_data[0]); // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!armed)
        (rd_data & 8'hEC) == 8'h00); // R10
    AST_HOLD: assert property (@(posedge clk) disable iff (!armed || pin_rst)
        (!wr_en && !wdog_pulse && !clkmon_pulse && !lowv_pulse) |=> $stable(rd_data)); // R11
endmodule

bind reset_cause_reg rcf_checker u_chk (
    .clk          (clk),
    .pin_rst      (pin_rst),
    .wdog_pulse   (wdog_pulse),
    .clkmon_pulse (clkmon_pulse),
    .lowv_pulse   (lowv_pulse),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data)
);

// File: tb/reset_cause_reg_test.sv
`timescale 1ns/1ps
module reset_cause_reg_test;
    logic       clk = 1'b0;
    logic       pin_rst = 1'b0;
    logic       wdog_pulse = 1'b0;
    logic       clkmon_pulse = 1'b0;
    logic       lowv_pulse = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    reset_cause_reg uut (
        .clk(clk), .pin_rst(pin_rst), .wdog_pulse(wdog_pulse),
        .clkmon_pulse(clkmon_pulse), .lowv_pulse(lowv_pulse),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    // flag vector bit2 = watchdog (byte bit 4), bit1 = clock monitor (bit 1), bit0 = voltage (bit 0)
    function automatic logic [7:0] to_byte(input logic [2:0] f);
        return {3'b000, f[2], 2'b00, f[1], f[0]};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rd_data=%02h expected %02h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, then sample after the edge.
    task automatic cycle(input logic rst, input logic [2:0] pul,
                         input logic we, input logic [7:0] wd);
        @(negedge clk);
        pin_rst = rst;
        wdog_pulse = pul[2]; clkmon_pulse = pul[1]; lowv_pulse = pul[0];
        wr_en = we; wr_data = wd;
        @(posedge clk);
        #1;
        @(negedge clk);
        pin_rst = 1'b0; wdog_pulse = 1'b0; clkmon_pulse = 1'b0; lowv_pulse = 1'b0;
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cycle(1'b1, 3'b000, 1'b0, 8'h00);
        check("R1 reset state", rd_data, 8'h00);

        for (int init = 0; init < 8; init++) begin
            for (int pul = 0; pul < 8; pul++) begin
                for (int wm = 0; wm < 9; wm++) begin
                    logic [2:0] cur, keep, nxt, p, w;
                    logic       we;
                    logic [7:0] wd;
                    string      tag;
                    cur = init[2:0];
                    p   = pul[2:0];
                    we  = (wm < 8);
                    w   = wm[2:0];
                    // reserved bits driven to all ones or all zeros alternately
                    wd  = (wm % 2 == 0) ? (8'hEC | to_byte(w)) : to_byte(w);
                    cycle(1'b1, 3'b000, 1'b0, 8'h00);
                    cycle(1'b0, cur, 1'b0, 8'h00);
                    check("R6 multi-set preload", rd_data, to_byte(cur));
                    cycle(1'b0, p, we, wd);
                    keep = we ? w : 3'b111;
                    nxt  = (cur & keep) | p;
                    for (int b = 0; b < 3; b++) begin
                        if (p[b] && !keep[b])       tag = "R9 set beats clear";
                        else if (p[b])              tag = (b == 2) ? "R2 watchdog set" :
                                                          (b == 1) ? "R3 clkmon set" : "R4 lowv set";
                        else if (we && !keep[b])    tag = "R7 write clear";
                        else if (we && !cur[b])     tag = "R8 no software set";
                        else if (p != 3'b000)       tag = "R5 others preserved";
                        else                        tag = "R11 hold";
                        check(tag, rd_data & to_byte(3'b1 << b), to_byte(nxt & (3'b1 << b)));
                    end
                    check("R10 reserved zero", rd_data & 8'hEC, 8'h00);
                    if ($countones(p) > 1) check("R6 simultaneous set", rd_data, to_byte(nxt));
                    cycle(1'b0, 3'b000, 1'b0, 8'h00);
                    check("R11 read no side effect", rd_data, to_byte(nxt));
                    cycle(1'b1, p, 1'b1, 8'hFF);
                    check("R1 pin dominates", rd_data, 8'h00);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule